// File: doc/BRIEF.md
# March Program Marker Repair Unit

This unit takes a stored march program, held as a packed array of genes, and repairs the element-boundary markers so that the genes group into well-formed march elements. Each gene carries a head marker (opens an element), an addressing-order bit, a tail marker (closes an element) and a payload. The payload holds the operation, data, address-sequence and data-pattern fields and is passed through untouched. A malformed program is healed, never rejected: marker bits are only ever set and never cleared, so no gene content is lost.

A one-cycle `go` pulse captures the program and its runtime length. The unit then walks the adjacent gene pairs one per clock and makes the tail of each gene agree with the head of the next. It forces a head on the first gene and a tail on the last gene of the program. A one-cycle `done` pulse ends the run. At that point `prog_out` holds the repaired program and `fix_count` holds the number of marker bits that were changed. Both stay stable until the next accepted `go`. The unit is placed in front of a march engine so the engine only ever sees consistent element boundaries.

Top module: `march_mark_fix`

## Requirements
- R1: Gene layout: gene g occupies bits [g*GENE_W +: GENE_W] (GENE_W = 3 + PAY_W, default 8). Bit 0 of a gene is the head marker, bit 1 the addressing-order bit, bit 2 the tail marker, and bits above are payload. After a run, the head marker of gene 0 is 1.
- R2: After a run, the tail marker of gene L-1 is 1, where L is the effective program length.
- R3: For every pair i, i+1 with i+1 < L, after a run both the tail of gene i and the head of gene i+1 equal the OR of those two bits as captured at `go`.
- R4: Payload bits and addressing-order bits of every gene, and every bit of genes at index L and above, leave unchanged; no marker bit is ever cleared.
- R5: `fix_count` at `done` equals the number of marker bits that changed from 0 to 1 during the run.
- R6: If `go` is sampled at clock edge k while idle, `busy` is high from edge k until edge k+L. `done` is high for exactly the one cycle after edge k+L, and `busy` is low in that cycle.
- R7: A `go` pulse while `busy` is high is ignored; the running job completes with the program captured at the accepted `go`.
- R8: The length `prog_len` is clamped: 0 is treated as 1, and values above MAX_GENES are treated as MAX_GENES.
- R9: While idle with `go` low, `prog_out` and `fix_count` hold their values regardless of `prog_in`.
- R10: With L = 1, gene 0 ends with both head and tail markers set.
- R11: After reset, `busy`, `done`, `fix_count` and `prog_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, accepted only when idle |
| prog_len | input | $clog2(MAX_GENES+1) | Runtime program length in genes |
| prog_in | input | MAX_GENES*GENE_W | Packed program to repair |
| prog_out | output | MAX_GENES*GENE_W | Repaired program, held until the next run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | $clog2(2*MAX_GENES+1) | Count of marker bits set by the last run |

## Verification
The bound checker watches every cycle. It checks that each processed pair comes out with matching tail and head, that the first head and the last tail are set at their steps, and that no bit is cleared while a run is active. It also checks that the stored program is frozen while idle, that `done` lasts one cycle, and that `busy` ends only through `done`. Other behaviour can only be shown by the bench, which compares whole runs against its own model: the exact `fix_count` value, clamping of the length, payload pass-through beyond the length, rejection of a second `go` mid-run, and the run latency.

// File: rtl/march_mark_pkg.sv
package march_mark_pkg;

  localparam int HEAD_BIT = 0;
  localparam int DIR_BIT  = 1;
  localparam int TAIL_BIT = 2;
  localparam int MARK_W   = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PAIR = 2'd1,
    PH_LAST = 2'd2
  } phase_e;

  // Effective program length: at least one gene, at most the capacity.
  function automatic int clamp_len(input int raw, input int cap);
    int r;
    r = raw;
    if (r < 1)   r = 1;
    if (r > cap) r = cap;
    return r;
  endfunction

  // Shared boundary value for a neighbouring tail/head pair.
  function automatic logic link_of(input logic tail_a, input logic head_b);
    return tail_a | head_b;
  endfunction

  // Number of marker bits that a pair repair raises from 0 to 1.
  function automatic logic [1:0] link_cost(input logic tail_a, input logic head_b);
    logic l;
    l = link_of(tail_a, head_b);
    return {1'b0, l & ~tail_a} + {1'b0, l & ~head_b};
  endfunction

endpackage

// File: rtl/march_mark_ctrl.sv
module march_mark_ctrl
  import march_mark_pkg::*;
#(
  parameter int MAX_GENES = 16,
  parameter int LEN_W     = 5,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len_in,
  output logic             busy,
  output logic             done,
  output logic             load_ev,
  output logic             pair_ev,
  output logic             last_ev,
  output logic [IDX_W-1:0] pair_idx,
  output logic [LEN_W-1:0] len_q
);

  phase_e phase_q;
  logic   done_q;
  logic   pair_final;

  assign load_ev    = (phase_q == PH_IDLE) && go;
  assign pair_ev    = (phase_q == PH_PAIR);
  assign last_ev    = (phase_q == PH_LAST);
  assign busy       = (phase_q != PH_IDLE);
  assign done       = done_q;
  assign pair_final = ((LEN_W'(pair_idx) + LEN_W'(2)) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      pair_idx <= '0;
      len_q    <= LEN_W'(1);
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (go) begin
            len_q    <= len_in;
            pair_idx <= '0;
            phase_q  <= (len_in == LEN_W'(1)) ? PH_LAST : PH_PAIR;
          end
        end
        PH_PAIR: begin
          if (pair_final) phase_q <= PH_LAST;
          else            pair_idx <= pair_idx + 1'b1;
        end
        PH_LAST: begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/march_mark_link.sv
module march_mark_link
  import march_mark_pkg::*;
(
  input  logic       tail_a,
  input  logic       head_b,
  output logic       link,
  output logic [1:0] cost
);

  assign link = link_of(tail_a, head_b);
  assign cost = link_cost(tail_a, head_b);

endmodule

// File: rtl/march_mark_fix.sv
module march_mark_fix
  import march_mark_pkg::*;
#(
  parameter int MAX_GENES = 16,
  parameter int PAY_W     = 5
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        go,
  input  logic [$clog2(MAX_GENES+1)-1:0]              prog_len,
  input  logic [MAX_GENES*(march_mark_pkg::MARK_W+PAY_W)-1:0] prog_in,
  output logic [MAX_GENES*(march_mark_pkg::MARK_W+PAY_W)-1:0] prog_out,
  output logic                                        busy,
  output logic                                        done,
  output logic [$clog2(2*MAX_GENES+1)-1:0]            fix_count
);

  localparam int GENE_W = MARK_W + PAY_W;
  localparam int LEN_W  = $clog2(MAX_GENES + 1);
  localparam int IDX_W  = (MAX_GENES > 1) ? $clog2(MAX_GENES) : 1;
  localparam int CNT_W  = $clog2(2 * MAX_GENES + 1);

  logic [GENE_W-1:0] gene_q [MAX_GENES];
  logic [LEN_W-1:0]  len_in;
  logic [LEN_W-1:0]  len_q;
  logic              load_ev, pair_ev, last_ev;
  logic [IDX_W-1:0]  pair_idx, pair_nxt, last_idx;
  logic              link_val;
  logic [1:0]        link_cost_w;
  logic              head0_miss, last_miss;
  logic [CNT_W-1:0]  cnt_q;

  assign len_in   = LEN_W'(clamp_len(int'(prog_len), MAX_GENES));
  assign pair_nxt = pair_idx + 1'b1;
  assign last_idx = IDX_W'(len_q - 1'b1);

  march_mark_ctrl #(
    .MAX_GENES(MAX_GENES),
    .LEN_W    (LEN_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .len_in  (len_in),
    .busy    (busy),
    .done    (done),
    .load_ev (load_ev),
    .pair_ev (pair_ev),
    .last_ev (last_ev),
    .pair_idx(pair_idx),
    .len_q   (len_q)
  );

  march_mark_link u_link (
    .tail_a(gene_q[pair_idx][TAIL_BIT]),
    .head_b(gene_q[pair_nxt][HEAD_BIT]),
    .link  (link_val),
    .cost  (link_cost_w)
  );

  assign head0_miss = ~prog_in[HEAD_BIT];
  assign last_miss  = ~gene_q[last_idx][TAIL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < MAX_GENES; g++) gene_q[g] <= '0;
      cnt_q <= '0;
    end else if (load_ev) begin
      for (int g = 0; g < MAX_GENES; g++) gene_q[g] <= prog_in[g*GENE_W +: GENE_W];
      gene_q[0][HEAD_BIT] <= 1'b1;
      cnt_q <= CNT_W'(head0_miss);
    end else if (pair_ev) begin
      gene_q[pair_idx][TAIL_BIT] <= link_val;
      gene_q[pair_nxt][HEAD_BIT] <= link_val;
      cnt_q <= cnt_q + CNT_W'(link_cost_w);
    end else if (last_ev) begin
      gene_q[last_idx][TAIL_BIT] <= 1'b1;
      cnt_q <= cnt_q + CNT_W'(last_miss);
    end
  end

  for (genvar g = 0; g < MAX_GENES; g++) begin : g_out
    assign prog_out[g*GENE_W +: GENE_W] = gene_q[g];
  end

  assign fix_count = cnt_q;

endmodule

// File: rtl/march_mark_fix_chk.sv
module march_mark_fix_chk
  import march_mark_pkg::*;
#(
  parameter int MAX_GENES = 16,
  parameter int PAY_W     = 5
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   go,
  input logic                                   busy,
  input logic                                   done,
  input logic [MAX_GENES*(MARK_W+PAY_W)-1:0]    prog_out,
  input logic                                   load_ev,
  input logic                                   pair_ev,
  input logic                                   last_ev,
  input logic [((MAX_GENES>1)?$clog2(MAX_GENES):1)-1:0] pair_idx,
  input logic [((MAX_GENES>1)?$clog2(MAX_GENES):1)-1:0] pair_nxt,
  input logic [((MAX_GENES>1)?$clog2(MAX_GENES):1)-1:0] last_idx
);

  localparam int GENE_W = MARK_W + PAY_W;

  a_r1_first_head: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> prog_out[HEAD_BIT]);

  a_r3_pair_linked: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ev |=> (prog_out[int'($past(pair_idx))*GENE_W + TAIL_BIT] ==
                 prog_out[int'($past(pair_nxt))*GENE_W + HEAD_BIT]));

  a_r2_last_tail: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> prog_out[int'($past(last_idx))*GENE_W + TAIL_BIT]);

  a_r4_never_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (($past(prog_out) & ~prog_out) == '0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(prog_out));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

endmodule

bind march_mark_fix march_mark_fix_chk #(
  .MAX_GENES(MAX_GENES),
  .PAY_W    (PAY_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go),
  .busy    (busy),
  .done    (done),
  .prog_out(prog_out),
  .load_ev (load_ev),
  .pair_ev (pair_ev),
  .last_ev (last_ev),
  .pair_idx(pair_idx),
  .pair_nxt(pair_nxt),
  .last_idx(last_idx)
);

// File: tb/march_mark_fix_test.sv
`timescale 1ns/1ps
module march_mark_fix_test;

  localparam int NG  = 16;
  localparam int PW  = 5;
  localparam int GW  = 3 + PW;
  localparam int TOT = NG * GW;
  localparam int LW  = $clog2(NG + 1);
  localparam int CW  = $clog2(2 * NG + 1);
  localparam int H   = 0;
  localparam int T   = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           go = 1'b0;
  logic [LW-1:0]  prog_len = '0;
  logic [TOT-1:0] prog_in = '0;
  logic [TOT-1:0] prog_out;
  logic           busy, done;
  logic [CW-1:0]  fix_count;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  march_mark_fix #(.MAX_GENES(NG), .PAY_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .prog_len(prog_len),
    .prog_in(prog_in), .prog_out(prog_out), .busy(busy),
    .done(done), .fix_count(fix_count)
  );

  task automatic check(input bit ok, input string req, input logic [TOT-1:0] act,
                       input logic [TOT-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int raw);
    if (raw <= 0) return 1;
    if (raw >= NG) return NG;
    return raw;
  endfunction

  function automatic logic [TOT-1:0] marker_mask();
    logic [TOT-1:0] m = '0;
    for (int g = 0; g < NG; g++) begin
      m[g*GW + H] = 1'b1;
      m[g*GW + T] = 1'b1;
    end
    return m;
  endfunction

  // Bench model: mark every boundary that either side already claims.
  function automatic logic [TOT-1:0] model(input logic [TOT-1:0] src, input int raw);
    logic [TOT-1:0] d = src;
    int L = eff_len(raw);
    for (int b = 0; b + 1 < L; b++) begin
      if (src[b*GW + T] || src[(b+1)*GW + H]) begin
        d[b*GW + T]     = 1'b1;
        d[(b+1)*GW + H] = 1'b1;
      end
    end
    d[H] = 1'b1;
    d[(L-1)*GW + T] = 1'b1;
    return d;
  endfunction

  function automatic logic [TOT-1:0] rnd_prog();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_case(input logic [TOT-1:0] p, input int raw, input bit disturb);
    logic [TOT-1:0] exp, mk;
    int L, n;
    L   = eff_len(raw);
    exp = model(p, raw);
    mk  = marker_mask();
    @(negedge clk);
    prog_in  = p;
    prog_len = LW'(raw);
    go       = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    n  = 1;
    check(busy == 1'b1, "R6 busy after go", TOT'(busy), TOT'(1));
    if (disturb) begin
      // R7: a second start while running must not be taken
      go       = 1'b1;
      prog_in  = ~p;
      prog_len = LW'($urandom_range(1, NG));
    end
    while (!done && n < 60) begin
      @(posedge clk);
      @(negedge clk);
      go = 1'b0;
      n++;
    end
    check(n == L + 1, "R6 latency", TOT'(n), TOT'(L + 1));
    check(busy == 1'b0, "R6 busy low at done", TOT'(busy), TOT'(0));
    check(prog_out[H] == 1'b1, "R1 first head", prog_out, exp);
    check(prog_out[(L-1)*GW + T] == 1'b1, "R2 last tail", prog_out, exp);
    check(prog_out == exp, disturb ? "R7 ignored go" : "R3 pair links", prog_out, exp);
    check((prog_out & ~mk) == (p & ~mk), "R4 payload kept", prog_out & ~mk, p & ~mk);
    check((p & ~prog_out) == '0, "R4 no clear", prog_out, p);
    check(int'(fix_count) == $countones(exp ^ p), "R5 fix count",
          TOT'(fix_count), TOT'($countones(exp ^ p)));
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R6 done single", TOT'(done), TOT'(0));
  endtask

  task automatic idle_hold();
    logic [TOT-1:0] snap;
    logic [CW-1:0]  cnt;
    snap = prog_out;
    cnt  = fix_count;
    prog_in  = rnd_prog();
    prog_len = LW'($urandom_range(1, NG));
    repeat (3) @(negedge clk);
    check(prog_out == snap, "R9 idle hold", prog_out, snap);
    check(fix_count == cnt, "R9 count hold", TOT'(fix_count), TOT'(cnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: run never completed");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [TOT-1:0] p;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy == 1'b0 && done == 1'b0, "R11 reset flags", TOT'({busy, done}), '0);
    check(fix_count == '0, "R11 reset count", TOT'(fix_count), '0);
    check(prog_out == '0, "R11 reset program", prog_out, '0);
    rst_n = 1'b1;

    // directed corners
    run_case('0, NG, 1'b0);                  // empty markers, full length
    run_case('0, 1, 1'b0);                   // R10 single gene
    check(prog_out[H] && prog_out[T], "R10 single gene both", prog_out, TOT'(5));
    check(fix_count == CW'(2), "R10 single gene count", TOT'(fix_count), TOT'(2));
    run_case(rnd_prog(), 0, 1'b0);           // R8 zero length acts as one
    run_case(rnd_prog(), 20, 1'b0);          // R8 oversize acts as MAX
    p = '0; p[3*GW + T] = 1'b1;              // tail alone forces next head
    run_case(p, 8, 1'b0);
    check(prog_out[4*GW + H] == 1'b1, "R3 tail forces head", prog_out, model(p, 8));
    p = '0; p[6*GW + H] = 1'b1;              // head alone forces previous tail
    run_case(p, 8, 1'b0);
    check(prog_out[5*GW + T] == 1'b1, "R3 head forces tail", prog_out, model(p, 8));
    p = '1;
    run_case(p, NG, 1'b0);                   // already consistent
    check(fix_count == '0, "R5 nothing to fix", TOT'(fix_count), '0);
    p = rnd_prog();
    run_case(p, 5, 1'b0);                    // genes beyond length untouched
    check(prog_out[TOT-1:5*GW] == p[TOT-1:5*GW], "R4 beyond length",
          prog_out, p);
    idle_hold();
    run_case(rnd_prog(), 7, 1'b1);           // R7 disturbance

    // constrained random
    for (int k = 0; k < 60; k++) begin
      run_case(rnd_prog(), $urandom_range(0, 20), ($urandom_range(0, 4) == 0));
      if (k % 10 == 0) idle_hold();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule